// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block picks up to `ISSUE_W` instructions per cycle from a set of per-operation-class ready queues. Each queue presents only its head: the oldest ready instruction's sequence number, its thread, and whether it has been squashed. The selector visits the non-empty classes from oldest head to youngest and gives each one a single chance per cycle. A class whose operation needs no functional unit always issues. A class that needs a unit issues only when its unit-availability input is high; otherwise it is skipped and the scan moves on to the next class.

A squashed head is discarded. It is popped without issuing and does not use any of the cycle's issue bandwidth. Pops are combinational, so the queue can present its next head on the following cycle. The grant slots are registered and filled oldest first. Each class also has a release strobe that tells the unit pool when the unit used by an issue is free again. The strobe comes one cycle after issue for a pipelined unit, or after the full issue latency for a non-pipelined one. A saturation-free busy counter is kept for each class and thread.

Sequence numbers wrap. Age is decided by the sign of the modular difference between two heads. Equal numbers go to the lower class index.

Top module: `iss_select`

## Requirements
- R1: Grants are placed in slots in age order, slot 0 oldest. Head a is older than head b when (a − b) mod 2^SEQ_W has its top bit set.
- R2: At most ISSUE_W heads issue per cycle. Once ISSUE_W have issued, younger classes are neither popped nor counted as busy.
- R3: A squashed valid head that the scan reaches is popped in the same cycle. It gets no grant slot and does not count toward ISSUE_W.
- R4: A class with need_fu low issues whatever its fu_free input says.
- R5: A class with need_fu high and fu_free low is skipped, and the scan continues past it. Its busy_cnt for that class and the head's thread rises by one on the next cycle. That counter sits at bits [(c·NUM_THR + t)·CNT_W +: CNT_W].
- R6: hd_pop is combinational in the cycle the head issues or is discarded. The slot outputs iss_vld, iss_cls, iss_seq and iss_tid show the grant on the next cycle. Slot k uses field k of each flattened vector.
- R7: For an issue with need_fu high, fu_release of that class pulses for one cycle. With iss_lat ≤ 1 the pulse comes one cycle after the grant. With iss_lat = L > 1 it comes L cycles after the grant and not before.
- R8: An issue with need_fu low produces no fu_release.
- R9: When two heads have equal sequence numbers, the lower class index is older.
- R10: While rst is high, and on the first cycle after it, iss_vld, fu_release and every busy counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_vld | input | NUM_CLS | Class queue has a ready head |
| hd_seq | input | NUM_CLS*SEQ_W | Head sequence number per class |
| hd_sq | input | NUM_CLS | Head is squashed |
| hd_tid | input | NUM_CLS*TID_W | Head thread per class |
| need_fu | input | NUM_CLS | Class operation needs a functional unit |
| fu_free | input | NUM_CLS | A unit for the class is available |
| iss_lat | input | NUM_CLS*LAT_W | Issue latency of the class's unit |
| hd_pop | output | NUM_CLS | Pop strobe to each class queue |
| iss_vld | output | ISSUE_W | Grant slot valid (registered) |
| iss_cls | output | ISSUE_W*CLS_W | Class of each slot |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence number of each slot |
| iss_tid | output | ISSUE_W*TID_W | Thread of each slot |
| fu_release | output | NUM_CLS | Unit of the class becomes free (registered) |
| busy_cnt | output | NUM_CLS*NUM_THR*CNT_W | Busy events per class and thread |

## Verification
Pops are due in the same cycle as their head, so the bench drives each vector on a falling edge and samples hd_pop shortly after, before the next rising edge. The grant slots, busy counters and single-cycle releases are due one rising edge later, so they are read on the following falling edge, which is also when the next vector is applied. A long-latency release is due L edges after the grant. Its check samples the release on each falling edge across that window, expecting it low until edge L and low again afterwards.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
  // width needed to count 0..n inclusive
  function automatic int unsigned count_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/iss_age_rank.sv
module iss_age_rank #(
  parameter int NUM_CLS = 4,
  parameter int SEQ_W   = 8,
  parameter int RANK_W  = 3
) (
  input  logic [NUM_CLS-1:0]        issuable,
  input  logic [NUM_CLS*SEQ_W-1:0]  hd_seq,
  output logic [NUM_CLS*RANK_W-1:0] ahead
);
  function automatic logic precedes(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b,
                                    input int ia, input int ib);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1] || ((a == b) && (ia < ib));
  endfunction

  // For each class: how many issuing classes stand in front of it in age order
  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      logic [RANK_W-1:0] acc;
      acc = '0;
      for (int d = 0; d < NUM_CLS; d++) begin
        if (d != c && issuable[d] &&
            precedes(hd_seq[d*SEQ_W +: SEQ_W], hd_seq[c*SEQ_W +: SEQ_W], d, c))
          acc = acc + RANK_W'(1);
      end
      ahead[c*RANK_W +: RANK_W] = acc;
    end
  end
endmodule

// File: rtl/iss_slot_pack.sv
module iss_slot_pack #(
  parameter int NUM_CLS = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 1,
  parameter int CLS_W   = 2,
  parameter int RANK_W  = 3
) (
  input  logic [NUM_CLS-1:0]        grant,
  input  logic [NUM_CLS*RANK_W-1:0] ahead,
  input  logic [NUM_CLS*SEQ_W-1:0]  hd_seq,
  input  logic [NUM_CLS*TID_W-1:0]  hd_tid,
  output logic [ISSUE_W-1:0]        s_vld,
  output logic [ISSUE_W*CLS_W-1:0]  s_cls,
  output logic [ISSUE_W*SEQ_W-1:0]  s_seq,
  output logic [ISSUE_W*TID_W-1:0]  s_tid
);
  // Slot k takes the granted class with exactly k issuers in front of it
  always_comb begin
    s_vld = '0;
    s_cls = '0;
    s_seq = '0;
    s_tid = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      for (int c = 0; c < NUM_CLS; c++) begin
        if (grant[c] && ahead[c*RANK_W +: RANK_W] == RANK_W'(k)) begin
          s_vld[k]                 = 1'b1;
          s_cls[k*CLS_W +: CLS_W]  = CLS_W'(c);
          s_seq[k*SEQ_W +: SEQ_W]  = hd_seq[c*SEQ_W +: SEQ_W];
          s_tid[k*TID_W +: TID_W]  = hd_tid[c*TID_W +: TID_W];
        end
      end
    end
  end
endmodule

// File: rtl/iss_release_timer.sv
module iss_release_timer #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [LAT_W-1:0] lat,
  output logic             rel
);
  logic [LAT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      rel    <= 1'b0;
    end else begin
      rel <= (fire && lat <= LAT_W'(1)) || (remain == LAT_W'(1));
      if (fire && lat > LAT_W'(1))
        remain <= lat - LAT_W'(1);
      else if (remain != '0)
        remain <= remain - LAT_W'(1);
    end
  end
endmodule

// File: rtl/iss_select.sv
module iss_select #(
  parameter int NUM_CLS = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int NUM_THR = 2,
  parameter int CNT_W   = 8,
  parameter int LAT_W   = 3,
  localparam int CLS_W  = (NUM_CLS < 2) ? 1 : $clog2(NUM_CLS),
  localparam int TID_W  = (NUM_THR < 2) ? 1 : $clog2(NUM_THR)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_CLS-1:0]               hd_vld,
  input  logic [NUM_CLS*SEQ_W-1:0]         hd_seq,
  input  logic [NUM_CLS-1:0]               hd_sq,
  input  logic [NUM_CLS*TID_W-1:0]         hd_tid,
  input  logic [NUM_CLS-1:0]               need_fu,
  input  logic [NUM_CLS-1:0]               fu_free,
  input  logic [NUM_CLS*LAT_W-1:0]         iss_lat,
  output logic [NUM_CLS-1:0]               hd_pop,
  output logic [ISSUE_W-1:0]               iss_vld,
  output logic [ISSUE_W*CLS_W-1:0]         iss_cls,
  output logic [ISSUE_W*SEQ_W-1:0]         iss_seq,
  output logic [ISSUE_W*TID_W-1:0]         iss_tid,
  output logic [NUM_CLS-1:0]               fu_release,
  output logic [NUM_CLS*NUM_THR*CNT_W-1:0] busy_cnt
);
  localparam int RANK_W = iss_sel_pkg::count_w(NUM_CLS);

  logic [NUM_CLS-1:0]        live, issuable, in_window, grant, busy_hit;
  logic [NUM_CLS*RANK_W-1:0] ahead;
  logic [ISSUE_W-1:0]        s_vld;
  logic [ISSUE_W*CLS_W-1:0]  s_cls;
  logic [ISSUE_W*SEQ_W-1:0]  s_seq;
  logic [ISSUE_W*TID_W-1:0]  s_tid;

  assign live     = hd_vld & ~hd_sq;
  assign issuable = live & (~need_fu | fu_free);

  iss_age_rank #(.NUM_CLS(NUM_CLS), .SEQ_W(SEQ_W), .RANK_W(RANK_W)) u_rank (
    .issuable (issuable),
    .hd_seq   (hd_seq),
    .ahead    (ahead)
  );

  // a class is reached by the scan while fewer than ISSUE_W older classes issued
  always_comb begin
    for (int c = 0; c < NUM_CLS; c++)
      in_window[c] = ahead[c*RANK_W +: RANK_W] < RANK_W'(ISSUE_W);
  end

  assign grant    = issuable & in_window;
  assign busy_hit = live & need_fu & ~fu_free & in_window;
  assign hd_pop   = hd_vld & in_window & (hd_sq | issuable);

  iss_slot_pack #(
    .NUM_CLS(NUM_CLS), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W),
    .TID_W(TID_W), .CLS_W(CLS_W), .RANK_W(RANK_W)
  ) u_pack (
    .grant  (grant),
    .ahead  (ahead),
    .hd_seq (hd_seq),
    .hd_tid (hd_tid),
    .s_vld  (s_vld),
    .s_cls  (s_cls),
    .s_seq  (s_seq),
    .s_tid  (s_tid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld <= '0;
      iss_cls <= '0;
      iss_seq <= '0;
      iss_tid <= '0;
    end else begin
      iss_vld <= s_vld;
      iss_cls <= s_cls;
      iss_seq <= s_seq;
      iss_tid <= s_tid;
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    iss_release_timer #(.LAT_W(LAT_W)) u_rel (
      .clk  (clk),
      .rst  (rst),
      .fire (grant[c] & need_fu[c]),
      .lat  (iss_lat[c*LAT_W +: LAT_W]),
      .rel  (fu_release[c])
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      localparam int IDX = (c * NUM_THR + t) * CNT_W;
      always_ff @(posedge clk) begin
        if (rst)
          busy_cnt[IDX +: CNT_W] <= '0;
        else if (busy_hit[c] && hd_tid[c*TID_W +: TID_W] == TID_W'(t))
          busy_cnt[IDX +: CNT_W] <= busy_cnt[IDX +: CNT_W] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/iss_select_chk.sv
module iss_select_chk #(
  parameter int NUM_CLS = 4,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int NUM_THR = 2,
  parameter int CNT_W   = 8,
  parameter int LAT_W   = 3,
  parameter int CLS_W   = 2,
  parameter int TID_W   = 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_CLS-1:0]               hd_vld,
  input logic [NUM_CLS*SEQ_W-1:0]         hd_seq,
  input logic [NUM_CLS-1:0]               hd_sq,
  input logic [NUM_CLS-1:0]               need_fu,
  input logic [NUM_CLS*LAT_W-1:0]         iss_lat,
  input logic [NUM_CLS-1:0]               hd_pop,
  input logic [ISSUE_W-1:0]               iss_vld,
  input logic [ISSUE_W*CLS_W-1:0]         iss_cls,
  input logic [ISSUE_W*SEQ_W-1:0]         iss_seq,
  input logic [NUM_CLS-1:0]               fu_release
);
  logic [NUM_CLS-1:0] cls_in_slot;
  always_comb begin
    cls_in_slot = '0;
    for (int k = 0; k < ISSUE_W; k++)
      for (int c = 0; c < NUM_CLS; c++)
        if (iss_vld[k] && iss_cls[k*CLS_W +: CLS_W] == CLS_W'(c))
          cls_in_slot[c] = 1'b1;
  end

  // R2
  pop_width_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(hd_pop & ~hd_sq) <= ISSUE_W);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_c
    // R3
    pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
      hd_pop[c] |-> hd_vld[c]);
    // R6
    grant_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (hd_pop[c] && !hd_sq[c]) |=> cls_in_slot[c]);
    // R7
    rel_next_chk: assert property (@(posedge clk) disable iff (rst)
      (hd_pop[c] && !hd_sq[c] && need_fu[c] && iss_lat[c*LAT_W +: LAT_W] <= LAT_W'(1))
        |=> fu_release[c]);
  end

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_k
    logic [SEQ_W-1:0] gap;
    assign gap = iss_seq[(k-1)*SEQ_W +: SEQ_W] - iss_seq[k*SEQ_W +: SEQ_W];
    // R1
    slot_order_chk: assert property (@(posedge clk) disable iff (rst)
      iss_vld[k] |-> (iss_vld[k-1] && (gap[SEQ_W-1] || gap == '0)));
  end
endmodule

bind iss_select iss_select_chk #(
  .NUM_CLS(NUM_CLS), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .NUM_THR(NUM_THR),
  .CNT_W(CNT_W), .LAT_W(LAT_W), .CLS_W(CLS_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst(rst), .hd_vld(hd_vld), .hd_seq(hd_seq), .hd_sq(hd_sq),
  .need_fu(need_fu), .iss_lat(iss_lat), .hd_pop(hd_pop), .iss_vld(iss_vld),
  .iss_cls(iss_cls), .iss_seq(iss_seq), .fu_release(fu_release)
);

// File: tb/iss_select_test.sv
`timescale 1ns/1ps
module iss_select_test;
  localparam int NC = 4, W = 2, SW = 8, NT = 2, CW = 8, LW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [NC-1:0]       hd_vld, hd_sq, need_fu, fu_free, hd_pop, fu_release;
  logic [NC*SW-1:0]    hd_seq;
  logic [NC-1:0]       hd_tid;
  logic [NC*LW-1:0]    iss_lat;
  logic [W-1:0]        iss_vld;
  logic [W*2-1:0]      iss_cls;
  logic [W*SW-1:0]     iss_seq;
  logic [W-1:0]        iss_tid;
  logic [NC*NT*CW-1:0] busy_cnt;

  always #2 clk = ~clk;

  iss_select #(.NUM_CLS(NC), .ISSUE_W(W), .SEQ_W(SW), .NUM_THR(NT), .CNT_W(CW), .LAT_W(LW)) uut (
    .clk(clk), .rst(rst), .hd_vld(hd_vld), .hd_seq(hd_seq), .hd_sq(hd_sq), .hd_tid(hd_tid),
    .need_fu(need_fu), .fu_free(fu_free), .iss_lat(iss_lat), .hd_pop(hd_pop),
    .iss_vld(iss_vld), .iss_cls(iss_cls), .iss_seq(iss_seq), .iss_tid(iss_tid),
    .fu_release(fu_release), .busy_cnt(busy_cnt));

  int nchk = 0, nfail = 0;
  // state per class: 0 empty, 1 squashed, 2 no unit needed, 3 unit free, 4 unit busy
  int m_st[NC];
  int m_seq[NC];
  int m_tid[NC];
  logic [CW-1:0] eb[NC][NT];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit older(input int a, input int b, input int ia, input int ib);
    int d;
    d = (a - b) & ((1 << SW) - 1);
    return (d >= (1 << (SW - 1))) || (a == b && ia < ib);
  endfunction

  task automatic drive_idle();
    hd_vld = '0; hd_sq = '0; need_fu = '0; fu_free = '0;
    hd_seq = '0; hd_tid = '0;
    for (int c = 0; c < NC; c++) iss_lat[c*LW +: LW] = 3'd1;
  endtask

  // drive m_* on a falling edge, check pops, then registered results one edge later
  task automatic run_vec();
    bit vis[NC];
    int slot_c[W];
    int issued, best;
    logic [NC-1:0] ep, er;
    ep = '0; er = '0; issued = 0;
    for (int c = 0; c < NC; c++) begin
      vis[c] = 0;
      hd_vld[c]  = (m_st[c] != 0);
      hd_sq[c]   = (m_st[c] == 1);
      need_fu[c] = (m_st[c] >= 3);
      fu_free[c] = (m_st[c] == 3);
      hd_seq[c*SW +: SW] = SW'(m_seq[c]);
      hd_tid[c] = m_tid[c][0];
      iss_lat[c*LW +: LW] = 3'd1;
    end
    for (int s = 0; s < NC; s++) begin
      best = -1;
      for (int c = 0; c < NC; c++)
        if (m_st[c] != 0 && !vis[c] && (best < 0 || older(m_seq[c], m_seq[best], c, best)))
          best = c;
      if (best < 0 || issued >= W) break;
      vis[best] = 1;
      if (m_st[best] == 1) ep[best] = 1'b1;
      else if (m_st[best] == 4) eb[best][m_tid[best]] = eb[best][m_tid[best]] + 1'b1;
      else begin
        ep[best] = 1'b1;
        slot_c[issued] = best;
        issued++;
        if (m_st[best] == 3) er[best] = 1'b1;
      end
    end
    #1;
    chk(hd_pop == ep, "R3/R5/R6", "hd_pop", hd_pop, ep);
    @(negedge clk);
    for (int k = 0; k < W; k++) begin
      chk(iss_vld[k] == (k < issued), "R2/R4", "iss_vld slot", iss_vld[k], k < issued);
      if (k < issued) begin
        chk(iss_cls[k*2 +: 2] == 2'(slot_c[k]), "R1/R9", "iss_cls", iss_cls[k*2 +: 2], slot_c[k]);
        chk(iss_seq[k*SW +: SW] == SW'(m_seq[slot_c[k]]), "R1", "iss_seq",
            iss_seq[k*SW +: SW], m_seq[slot_c[k]]);
        chk(iss_tid[k] == m_tid[slot_c[k]][0], "R6", "iss_tid", iss_tid[k], m_tid[slot_c[k]]);
      end
    end
    chk(fu_release == er, "R7/R8", "fu_release", fu_release, er);
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < NT; t++)
        chk(busy_cnt[(c*NT+t)*CW +: CW] == eb[c][t], "R5", "busy_cnt",
            busy_cnt[(c*NT+t)*CW +: CW], eb[c][t]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    drive_idle();
    for (int c = 0; c < NC; c++) for (int t = 0; t < NT; t++) eb[c][t] = '0;
    repeat (3) @(negedge clk);
    chk(iss_vld == '0 && fu_release == '0 && busy_cnt == '0, "R10", "outputs in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(iss_vld == '0 && fu_release == '0 && busy_cnt == '0, "R10", "outputs after reset", 0, 0);

    // exhaustive over five head states per class, seq base walking through wraparound
    for (int v = 0; v < 625; v++) begin
      int q;
      q = v;
      for (int c = 0; c < NC; c++) begin
        m_st[c]  = q % 5;
        q        = q / 5;
        m_seq[c] = (v * 7 + ((c * 3 + v) % 4) * 5) & 255;
        m_tid[c] = (c + v) & 1;
      end
      run_vec();
    end

    // R1 wraparound: 250 and 254 are older than 0 and 3
    m_st = '{2, 2, 2, 2};
    m_seq = '{250, 3, 254, 0};
    m_tid = '{0, 1, 0, 1};
    run_vec();
    chk(iss_cls == {2'd2, 2'd0}, "R1", "wrap slots", iss_cls, {2'd2, 2'd0});

    // R9 equal sequence numbers: lower class first
    m_st = '{0, 2, 0, 2};
    m_seq = '{0, 10, 0, 10};
    run_vec();
    chk(iss_cls == {2'd3, 2'd1}, "R9", "tie slots", iss_cls, {2'd3, 2'd1});

    // R7 non-pipelined unit, latency 3: release due three edges after grant
    drive_idle();
    hd_vld[0] = 1'b1; need_fu[0] = 1'b1; fu_free[0] = 1'b1;
    iss_lat[0 +: LW] = 3'd3; hd_seq[0 +: SW] = 8'd40;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      drive_idle();
      chk(fu_release[0] == (e == 3), "R7", "release lat3", fu_release[0], e == 3);
    end
    // R7 latency 2
    hd_vld[1] = 1'b1; need_fu[1] = 1'b1; fu_free[1] = 1'b1;
    iss_lat[LW +: LW] = 3'd2; hd_seq[SW +: SW] = 8'd41;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      drive_idle();
      chk(fu_release[1] == (e == 2), "R7", "release lat2", fu_release[1], e == 2);
    end
    // R8 no unit needed: no release whatever latency
    hd_vld[2] = 1'b1; iss_lat[2*LW +: LW] = 3'd2; hd_seq[2*SW +: SW] = 8'd42;
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      drive_idle();
      chk(fu_release == '0, "R8", "release without unit", fu_release, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule